// File: doc/BRIEF.md
# Interrupt Mode Sequencer

This block is the part of a processor core that decides whether to take one of two interrupt request lines: a normal request and a fast request. It keeps the current processor mode (supervisor, normal-interrupt or fast-interrupt) and two disable flags, one for each line. When a request is taken, the block switches mode and sets the flags that belong to the new mode. In the cycle after that it raises a vector strobe, and the vector address shows where the handler starts.

A fixed nesting rule applies. A normal handler can be preempted only by a fast request, and a fast handler cannot be preempted at all. A mode is entered on its own, but it is left only through an explicit return command from the handler. The return restores the mode and flags that were saved at entry, using a two-level saved-context stack. The running code can also write both flags through a flag-write port.

Top module: `irq_mode_seq`

## Requirements
- R1: After reset the mode is supervisor (code 0), both disable flags are 0 and the vector strobe is low.
- R2: In supervisor mode with the normal flag at 0, an asserted normal line gives, one clock later: normal-interrupt mode (code 1), the normal flag at 1, the fast flag unchanged, and the strobe high with address 0x18.
- R3: In supervisor or normal-interrupt mode with the fast flag at 0, an asserted fast line gives, one clock later: fast-interrupt mode (code 2), both flags at 1, and the strobe high with address 0x1C.
- R4: If both lines are asserted and both can be taken in the same cycle, the fast request is taken.
- R5: While a line's disable flag is 1, asserting that line changes neither the mode nor the strobe.
- R6: In normal-interrupt mode the normal line is ignored, even when it is held high.
- R7: In fast-interrupt mode neither line causes a new entry, whatever the flags hold.
- R8: A return command in an interrupt mode restores the mode and both flags saved at the most recent entry. A fast entry nested in a normal one therefore returns to normal mode first, and then to supervisor.
- R9: A return command in supervisor mode has no effect.
- R10: If the normal line is still high when a return brings back supervisor mode with the normal flag at 0, the normal interrupt is entered again on the next clock, with a fresh strobe.
- R11: The strobe is high only in the cycle right after an entry is taken, and never after a return or a flag write.
- R12: A flag write (bit 0 normal, bit 1 fast) updates both flags one clock later, unless a return or an entry happens in the same cycle, in which case the write is dropped.
- R13: A return command takes priority over any request in the same cycle. A fast request that arrives together with a return in normal mode is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nrm_req | input | 1 | Normal interrupt request line |
| fst_req | input | 1 | Fast interrupt request line |
| ret_cmd | input | 1 | Return command from the handler |
| flag_wr | input | 1 | Flag write enable |
| flag_wdata | input | 2 | New flags: bit 0 normal disable, bit 1 fast disable |
| mode_o | output | 2 | Current mode: 0 supervisor, 1 normal, 2 fast |
| nmask_o | output | 1 | Normal-line disable flag |
| fmask_o | output | 1 | Fast-line disable flag |
| vec_stb_o | output | 1 | One-cycle vector fetch strobe |
| vec_addr_o | output | ADDR_W | Vector address, valid while the strobe is high |

## Verification
The main function is tried with these patterns:
- A normal line held high across an entry and two returns. This separates being ignored in normal mode from re-entry after a return.
- A fast line raised inside a normal handler, and the reverse order. These show that nesting works in one direction only.
- Both lines raised together, from supervisor mode and from inside the fast handler. These separate the arbitration order from the fast-mode lock.
- Flag writes, then requests against the written flags. This separates blocking by flag from blocking by mode.
- Return commands that coincide with requests or flag writes. These expose the priority order.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SUP = 2'd0,
    MODE_NRM = 2'd1,
    MODE_FST = 2'd2
  } mode_e;

  typedef struct packed {
    mode_e mode;
    logic  nmask;
    logic  fmask;
  } ctx_t;

  // a fast request may enter from any mode except fast itself
  function automatic logic fst_allowed(mode_e m, logic fmask);
    return (m != MODE_FST) && !fmask;
  endfunction

  // a normal request may only enter from supervisor
  function automatic logic nrm_allowed(mode_e m, logic nmask);
    return (m == MODE_SUP) && !nmask;
  endfunction

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_seq_pkg::*;
(
  input  mode_e mode,
  input  logic  nmask,
  input  logic  fmask,
  input  logic  nrm_req,
  input  logic  fst_req,
  input  logic  ret_cmd,
  output logic  do_ret,
  output logic  take_fst,
  output logic  take_nrm
);

  always_comb begin
    do_ret   = ret_cmd && (mode != MODE_SUP);
    take_fst = !do_ret && fst_req && fst_allowed(mode, fmask);
    take_nrm = !do_ret && !take_fst && nrm_req && nrm_allowed(mode, nmask);
  end

endmodule

// File: rtl/irq_ctx_stack.sv
module irq_ctx_stack
  import irq_seq_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  input  ctx_t push_ctx,
  output ctx_t top_ctx
);

  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [LVL_W-1:0] level_q;
  ctx_t             slot_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
    end else if (push && (level_q != LVL_W'(DEPTH))) begin
      level_q <= level_q + 1'b1;
    end else if (pop && (level_q != '0)) begin
      level_q <= level_q - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '{mode: MODE_SUP, nmask: 1'b0, fmask: 1'b0};
      end else if (push && (level_q == LVL_W'(g))) begin
        slot_q[g] <= push_ctx;
      end
    end
  end

  always_comb begin
    top_ctx = '{mode: MODE_SUP, nmask: 1'b0, fmask: 1'b0};
    for (int i = 0; i < DEPTH; i++) begin
      if (level_q == LVL_W'(i + 1)) top_ctx = slot_q[i];
    end
  end

endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen #(
  parameter int              ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] VEC_NRM = ADDR_W'(32'h18),
  parameter logic [ADDR_W-1:0] VEC_FST = ADDR_W'(32'h1C)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_nrm,
  input  logic              take_fst,
  output logic              vec_stb,
  output logic [ADDR_W-1:0] vec_addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_stb  <= 1'b0;
      vec_addr <= '0;
    end else begin
      vec_stb <= take_nrm || take_fst;
      if (take_fst)      vec_addr <= VEC_FST;
      else if (take_nrm) vec_addr <= VEC_NRM;
    end
  end

endmodule

// File: rtl/irq_mode_seq.sv
module irq_mode_seq
  import irq_seq_pkg::*;
#(
  parameter int                ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] VEC_NRM = ADDR_W'(32'h18),
  parameter logic [ADDR_W-1:0] VEC_FST = ADDR_W'(32'h1C)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nrm_req,
  input  logic              fst_req,
  input  logic              ret_cmd,
  input  logic              flag_wr,
  input  logic [1:0]        flag_wdata,
  output logic [1:0]        mode_o,
  output logic              nmask_o,
  output logic              fmask_o,
  output logic              vec_stb_o,
  output logic [ADDR_W-1:0] vec_addr_o
);

  localparam int NEST_DEPTH = 2;

  mode_e mode_q;
  logic  nmask_q;
  logic  fmask_q;
  logic  do_ret;
  logic  take_fst;
  logic  take_nrm;
  ctx_t  cur_ctx;
  ctx_t  top_ctx;

  irq_arbiter u_arb (
    .mode     (mode_q),
    .nmask    (nmask_q),
    .fmask    (fmask_q),
    .nrm_req  (nrm_req),
    .fst_req  (fst_req),
    .ret_cmd  (ret_cmd),
    .do_ret   (do_ret),
    .take_fst (take_fst),
    .take_nrm (take_nrm)
  );

  assign cur_ctx = '{mode: mode_q, nmask: nmask_q, fmask: fmask_q};

  irq_ctx_stack #(.DEPTH(NEST_DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (take_fst || take_nrm),
    .pop      (do_ret),
    .push_ctx (cur_ctx),
    .top_ctx  (top_ctx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_SUP;
      nmask_q <= 1'b0;
      fmask_q <= 1'b0;
    end else if (do_ret) begin
      mode_q  <= top_ctx.mode;
      nmask_q <= top_ctx.nmask;
      fmask_q <= top_ctx.fmask;
    end else if (take_fst) begin
      mode_q  <= MODE_FST;
      nmask_q <= 1'b1;
      fmask_q <= 1'b1;
    end else if (take_nrm) begin
      mode_q  <= MODE_NRM;
      nmask_q <= 1'b1;
    end else if (flag_wr) begin
      nmask_q <= flag_wdata[0];
      fmask_q <= flag_wdata[1];
    end
  end

  irq_vec_gen #(.ADDR_W(ADDR_W), .VEC_NRM(VEC_NRM), .VEC_FST(VEC_FST)) u_vec (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_nrm (take_nrm),
    .take_fst (take_fst),
    .vec_stb  (vec_stb_o),
    .vec_addr (vec_addr_o)
  );

  assign mode_o  = mode_q;
  assign nmask_o = nmask_q;
  assign fmask_o = fmask_q;

endmodule

// File: rtl/irq_mode_seq_chk.sv
module irq_mode_seq_chk #(
  parameter int                ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] VEC_NRM = ADDR_W'(32'h18),
  parameter logic [ADDR_W-1:0] VEC_FST = ADDR_W'(32'h1C)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nrm_req,
  input logic              fst_req,
  input logic              ret_cmd,
  input logic [1:0]        mode_o,
  input logic              nmask_o,
  input logic              fmask_o,
  input logic              vec_stb_o,
  input logic [ADDR_W-1:0] vec_addr_o,
  input logic              do_ret,
  input logic              take_fst,
  input logic              take_nrm
);

  p_nrm_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_nrm |=> (mode_o == 2'd1) && nmask_o && vec_stb_o && (vec_addr_o == VEC_NRM));

  p_fst_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_fst |=> (mode_o == 2'd2) && nmask_o && fmask_o && vec_stb_o && (vec_addr_o == VEC_FST));

  p_fst_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0) && nrm_req && fst_req && !nmask_o && !fmask_o && !ret_cmd
      |=> vec_stb_o && (vec_addr_o == VEC_FST));

  p_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0) && nmask_o && fmask_o |=> !vec_stb_o);

  p_nrm_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1) && !ret_cmd && !fst_req |=> (mode_o == 2'd1) && !vec_stb_o);

  p_fst_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2) && !ret_cmd |=> (mode_o == 2'd2) && !vec_stb_o);

  p_sup_ret_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0) && ret_cmd && !nrm_req && !fst_req |=> (mode_o == 2'd0));

  p_stb_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    vec_stb_o |-> $past(take_fst || take_nrm));

  p_ret_first_r13: assert property (@(posedge clk) disable iff (!rst_n)
    do_ret |=> !vec_stb_o);

endmodule

bind irq_mode_seq irq_mode_seq_chk #(
  .ADDR_W(ADDR_W), .VEC_NRM(VEC_NRM), .VEC_FST(VEC_FST)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .nrm_req    (nrm_req),
  .fst_req    (fst_req),
  .ret_cmd    (ret_cmd),
  .mode_o     (mode_o),
  .nmask_o    (nmask_o),
  .fmask_o    (fmask_o),
  .vec_stb_o  (vec_stb_o),
  .vec_addr_o (vec_addr_o),
  .do_ret     (do_ret),
  .take_fst   (take_fst),
  .take_nrm   (take_nrm)
);

// File: tb/irq_mode_seq_tb_top.sv
module irq_mode_seq_tb_top;

  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              nrm_req = 1'b0;
  logic              fst_req = 1'b0;
  logic              ret_cmd = 1'b0;
  logic              flag_wr = 1'b0;
  logic [1:0]        flag_wdata = 2'b00;
  logic [1:0]        mode_o;
  logic              nmask_o;
  logic              fmask_o;
  logic              vec_stb_o;
  logic [ADDR_W-1:0] vec_addr_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_mode_seq dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .nrm_req    (nrm_req),
    .fst_req    (fst_req),
    .ret_cmd    (ret_cmd),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .mode_o     (mode_o),
    .nmask_o    (nmask_o),
    .fmask_o    (fmask_o),
    .vec_stb_o  (vec_stb_o),
    .vec_addr_o (vec_addr_o)
  );

  typedef struct {
    logic [1:0]  mode;
    logic        nm;
    logic        fm;
    logic        stb;
    logic [31:0] addr;
    string       tag;
  } exp_t;

  exp_t       sb_q[$];
  logic [3:0] m_saved[$];
  logic [1:0] m_mode = 2'd0;
  logic       m_nm = 1'b0;
  logic       m_fm = 1'b0;

  // reference model: one clocked step worked out from the requirements
  task automatic step(input logic n, input logic f, input logic r,
                      input logic w, input logic [1:0] wd, input string tag);
    exp_t e;
    @(negedge clk);
    nrm_req = n; fst_req = f; ret_cmd = r; flag_wr = w; flag_wdata = wd;
    e.stb = 1'b0; e.addr = 32'h0; e.tag = tag;
    if (r && m_mode != 2'd0) begin
      {m_mode, m_nm, m_fm} = m_saved.pop_back();
    end else if (f && !m_fm && m_mode != 2'd2) begin
      m_saved.push_back({m_mode, m_nm, m_fm});
      m_mode = 2'd2; m_nm = 1'b1; m_fm = 1'b1;
      e.stb = 1'b1; e.addr = 32'h1C;
    end else if (n && !m_nm && m_mode == 2'd0) begin
      m_saved.push_back({m_mode, m_nm, m_fm});
      m_mode = 2'd1; m_nm = 1'b1;
      e.stb = 1'b1; e.addr = 32'h18;
    end else if (w) begin
      m_nm = wd[0]; m_fm = wd[1];
    end
    e.mode = m_mode; e.nm = m_nm; e.fm = m_fm;
    sb_q.push_back(e);
  endtask

  // monitor: compares after each rising edge, away from it
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (sb_q.size() != 0) begin
        exp_t e;
        logic ok;
        e = sb_q.pop_front();
        ok = (mode_o == e.mode) && (nmask_o == e.nm) && (fmask_o == e.fm) &&
             (vec_stb_o == e.stb) && (!e.stb || vec_addr_o == e.addr);
        checks++;
        if (!ok) begin
          errors++;
          $display("FAIL %s: got mode=%0d nm=%0b fm=%0b stb=%0b addr=%h, expected mode=%0d nm=%0b fm=%0b stb=%0b addr=%h",
                   e.tag, mode_o, nmask_o, fmask_o, vec_stb_o, vec_addr_o,
                   e.mode, e.nm, e.fm, e.stb, e.addr);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (mode_o !== 2'd0 || nmask_o !== 1'b0 || fmask_o !== 1'b0 || vec_stb_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: got mode=%0d nm=%0b fm=%0b stb=%0b, expected 0 0 0 0",
               mode_o, nmask_o, fmask_o, vec_stb_o);
    end
    step(0, 0, 0, 0, 2'b00, "R1 idle");
    // R2 then R6: normal entry, line held
    step(1, 0, 0, 0, 2'b00, "R2 normal entry");
    step(1, 0, 0, 0, 2'b00, "R6 held normal ignored");
    step(1, 0, 0, 0, 2'b00, "R6 held normal ignored");
    // R3 nested fast, then R7 lock
    step(1, 1, 0, 0, 2'b00, "R3 fast preempts normal");
    step(1, 1, 0, 0, 2'b00, "R7 fast mode closed");
    step(1, 1, 0, 1, 2'b00, "R7 closed after flag clear");
    step(1, 1, 0, 0, 2'b00, "R7 closed with flags clear");
    // R8 returns, R10 re-entry
    step(1, 0, 1, 0, 2'b00, "R8 return to normal");
    step(1, 0, 0, 0, 2'b00, "R6 normal still ignored");
    step(1, 0, 1, 0, 2'b00, "R8 return to supervisor");
    step(1, 0, 0, 0, 2'b00, "R10 re-entry on held line");
    step(0, 0, 1, 0, 2'b00, "R8 return");
    // R9
    step(0, 0, 1, 0, 2'b00, "R9 return in supervisor");
    step(0, 0, 0, 0, 2'b00, "R11 strobe low");
    // R4
    step(1, 1, 0, 0, 2'b00, "R4 fast wins");
    step(0, 0, 1, 0, 2'b00, "R8 fast return to supervisor");
    // R12, R5
    step(0, 0, 0, 1, 2'b11, "R12 flag write");
    step(1, 1, 0, 0, 2'b00, "R5 both masked");
    step(0, 0, 0, 1, 2'b01, "R12 flag write partial");
    step(1, 0, 0, 0, 2'b00, "R5 normal masked");
    step(0, 1, 0, 0, 2'b00, "R3 fast from supervisor");
    step(0, 0, 1, 0, 2'b00, "R8 restore written flags");
    step(0, 0, 0, 1, 2'b00, "R12 clear flags");
    step(1, 0, 0, 1, 2'b11, "R12 write dropped on entry");
    // R13
    step(0, 1, 1, 0, 2'b00, "R13 return beats fast");
    step(0, 0, 0, 0, 2'b00, "R11 no strobe after return");
    step(1, 0, 0, 0, 2'b00, "R2 entry again");
    step(0, 0, 1, 1, 2'b11, "R12 write dropped on return");
    step(0, 0, 0, 0, 2'b00, "R11 idle");
    repeat (3) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule